// File: doc/BRIEF.md
# Transceiver Register-Port Write Sequencer

This block writes one 16-bit value into an internal register of a transceiver over a request/acknowledge control port. A single `go_i` pulse hands it an address and a data word. It then runs three complete four-phase handshakes in a fixed order: it captures the address, then captures the data, then commits the write. Each handshake uses its own command strobe.

Every handshake has the same shape. The block puts the value for the step on the shared 16-bit bus, with every strobe low, for one cycle. It then raises the strobe for the step and waits for acknowledge to go high. Next it lowers the strobe, keeps the bus value, and waits for acknowledge to go low. The acknowledge input crosses a two-flop synchroniser before the sequencer uses it. Each of the two waits in a handshake has its own budget of `TIMEOUT_CYC` clock cycles. If either wait runs out, the remaining steps are dropped and a one-cycle timeout pulse is given. A one-cycle done pulse marks a finished write.

Top module: `xcvr_regwr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_o`, `bus_data_o`, `done_o` and `timeout_o` are all zero.
- R2: `cmd_o` has at most one bit set. Bit 0 is capture-address, bit 1 is capture-data, bit 2 is read and bit 3 is write-commit. Bit 2 is never set.
- R3: A write raises strobes in the order bit 0, bit 1, bit 3. The bus carries the address under bit 0 and the data word under bits 1 and 3.
- R4: Before each strobe rises, the bus holds that step's value for at least one cycle with `cmd_o` zero. The bus does not change while a strobe is high or in the cycle it falls.
- R5: A strobe stays high until the synchronised acknowledge is high and then falls. The next step starts only after the synchronised acknowledge is low again.
- R6: The acknowledge reaches the sequencer through two flops. If the responder changes `ack_i` within `TIMEOUT_CYC`-3 cycles of the start of a wait, that wait completes. If it changes later, the wait times out (`TIMEOUT_CYC` >= 3).
- R7: If acknowledge is not seen high, the strobe stays high for exactly `TIMEOUT_CYC` cycles. It then falls, `timeout_o` pulses, and no further strobe is raised.
- R8: If acknowledge is not seen low, `timeout_o` pulses `TIMEOUT_CYC` cycles after the strobe fell, and no further strobe is raised. The wait budget restarts at the start of every wait.
- R9: `go_i` is accepted only when the block is idle. A `go_i` during a write changes neither the captured address and data nor the number of strobes.
- R10: `done_o` and `timeout_o` are single-cycle pulses and are never high together. `done_o` follows only the release of the commit handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start a write (taken only when idle) |
| addr_i | input | 16 | Target register address, sampled on an accepted go |
| data_i | input | 16 | Value to write, sampled on an accepted go |
| ack_i | input | 1 | Acknowledge from the register port (asynchronous) |
| bus_data_o | output | 16 | Shared data bus to the register port |
| cmd_o | output | 4 | One-hot command strobes: [0] capture-address, [1] capture-data, [2] read (unused), [3] write-commit |
| done_o | output | 1 | One-cycle pulse when a write has completed |
| timeout_o | output | 1 | One-cycle pulse when an acknowledge wait expired |

## Verification
The bench sweeps the responder's rise and release delays across the timeout edge. The last delay that still succeeds and the first that fails must be exactly `TIMEOUT_CYC`-3 and `TIMEOUT_CYC`-2. A design that lost or added a synchroniser stage, or let expiry win over a late acknowledge, moves that edge. For each of the three handshakes, the bench hangs the acknowledge both high and low. It then checks the exact strobe-high or wait length, checks that later steps are dropped, and checks that the block recovers for the next write. A design that did not reload its counter per wait would fail the run in which every one of the six waits uses the full budget. A design that accepted `go_i` mid-write would show up as changed captured values or extra strobes.

// File: rtl/xcvr_regwr_pkg.sv
package xcvr_regwr_pkg;

    localparam int REG_W = 16;
    localparam int CMD_W = 4;

    localparam int CMD_ADDR_BIT  = 0;
    localparam int CMD_DATA_BIT  = 1;
    localparam int CMD_READ_BIT  = 2;
    localparam int CMD_WRITE_BIT = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RAISE,
        ST_DROP
    } seq_state_e;

    typedef enum logic [1:0] {
        STEP_ADDR,
        STEP_DATA,
        STEP_COMMIT
    } step_e;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
    } wr_req_t;

    function automatic logic [CMD_W-1:0] step_cmd(step_e s);
        logic [CMD_W-1:0] c;
        c = '0;
        case (s)
            STEP_ADDR:   c[CMD_ADDR_BIT]  = 1'b1;
            STEP_DATA:   c[CMD_DATA_BIT]  = 1'b1;
            STEP_COMMIT: c[CMD_WRITE_BIT] = 1'b1;
            default:     c = '0;
        endcase
        return c;
    endfunction

    function automatic step_e next_step(step_e s);
        case (s)
            STEP_ADDR: return STEP_DATA;
            default:   return STEP_COMMIT;
        endcase
    endfunction

endpackage

// File: rtl/xcvr_regwr_sync.sv
module xcvr_regwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shift_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) shift_q <= '0;
                else     shift_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) shift_q <= '0;
                else     shift_q <= {shift_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/xcvr_regwr_timer.sv
module xcvr_regwr_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);
    localparam int            CW     = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] RELOAD = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load_i)        cnt_q <= RELOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/xcvr_regwr_fsm.sv
module xcvr_regwr_fsm
    import xcvr_regwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  logic       ack_s_i,
    input  logic       expired_i,
    output seq_state_e state_o,
    output step_e      step_o,
    output logic       accept_o,
    output logic       load_o,
    output logic       done_o,
    output logic       timeout_o
);
    seq_state_e st_q, st_d;
    step_e      step_q, step_d;
    logic       done_q, done_d;
    logic       to_q, to_d;

    always_comb begin
        st_d     = st_q;
        step_d   = step_q;
        accept_o = 1'b0;
        load_o   = 1'b0;
        done_d   = 1'b0;
        to_d     = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (go_i) begin
                    accept_o = 1'b1;
                    step_d   = STEP_ADDR;
                    st_d     = ST_SETUP;
                end
            end
            ST_SETUP: begin
                st_d   = ST_RAISE;
                load_o = 1'b1;
            end
            ST_RAISE: begin
                if (ack_s_i) begin
                    st_d   = ST_DROP;
                    load_o = 1'b1;
                end else if (expired_i) begin
                    st_d = ST_IDLE;
                    to_d = 1'b1;
                end
            end
            ST_DROP: begin
                if (!ack_s_i) begin
                    if (step_q == STEP_COMMIT) begin
                        st_d   = ST_IDLE;
                        done_d = 1'b1;
                    end else begin
                        step_d = next_step(step_q);
                        st_d   = ST_SETUP;
                    end
                end else if (expired_i) begin
                    st_d = ST_IDLE;
                    to_d = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            step_q <= STEP_ADDR;
            done_q <= 1'b0;
            to_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            step_q <= step_d;
            done_q <= done_d;
            to_q   <= to_d;
        end
    end

    assign state_o   = st_q;
    assign step_o    = step_q;
    assign done_o    = done_q;
    assign timeout_o = to_q;
endmodule

// File: rtl/xcvr_regwr_seq.sv
module xcvr_regwr_seq
    import xcvr_regwr_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [REG_W-1:0] addr_i,
    input  logic [REG_W-1:0] data_i,
    input  logic             ack_i,
    output logic [REG_W-1:0] bus_data_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic             done_o,
    output logic             timeout_o
);
    logic       ack_s;
    logic       expired;
    logic       accept;
    logic       load;
    seq_state_e state;
    step_e      step;
    wr_req_t    req_q;

    xcvr_regwr_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ack_i),
        .q_o (ack_s)
    );

    xcvr_regwr_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .expired_o (expired)
    );

    xcvr_regwr_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .go_i      (go_i),
        .ack_s_i   (ack_s),
        .expired_i (expired),
        .state_o   (state),
        .step_o    (step),
        .accept_o  (accept),
        .load_o    (load),
        .done_o    (done_o),
        .timeout_o (timeout_o)
    );

    always_ff @(posedge clk) begin
        if (rst)         req_q <= '0;
        else if (accept) req_q <= '{addr: addr_i, data: data_i};
    end

    assign bus_data_o = (step == STEP_ADDR) ? req_q.addr : req_q.data;
    assign cmd_o      = (state == ST_RAISE) ? step_cmd(step) : '0;
endmodule

// File: rtl/xcvr_regwr_chk.sv
module xcvr_regwr_chk
    import xcvr_regwr_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5000
) (
    input logic             clk,
    input logic             rst,
    input logic             ack_i,
    input logic [REG_W-1:0] bus_data_o,
    input logic [CMD_W-1:0] cmd_o,
    input logic             done_o,
    input logic             timeout_o
);
    localparam int HW = $clog2(TIMEOUT_CYC + 2);

    logic [HW-1:0]    hi_run;
    logic [CMD_W-1:0] last_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run   <= '0;
            last_cmd <= '0;
        end else begin
            hi_run <= (cmd_o != '0) ? hi_run + 1'b1 : '0;
            if (cmd_o != '0) last_cmd <= cmd_o;
        end
    end

    assert_onehot_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_o));
    assert_no_read_R2: assert property (@(posedge clk) disable iff (rst)
        !cmd_o[CMD_READ_BIT]);
    assert_data_after_addr_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_o[CMD_DATA_BIT]) |-> last_cmd == 4'b0001);
    assert_commit_after_data_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_o[CMD_WRITE_BIT]) |-> last_cmd == 4'b0010);
    assert_bus_held_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != '0) |-> $stable(bus_data_o));
    assert_bus_held_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_o != '0) |-> $stable(bus_data_o));
    assert_ack_synced_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(cmd_o != '0) && !timeout_o) |-> $past(ack_i, 3));
    assert_strobe_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        hi_run <= HW'(TIMEOUT_CYC));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_timeout_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);
    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(done_o && timeout_o));
endmodule

bind xcvr_regwr_seq xcvr_regwr_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .ack_i      (ack_i),
    .bus_data_o (bus_data_o),
    .cmd_o      (cmd_o),
    .done_o     (done_o),
    .timeout_o  (timeout_o)
);

// File: tb/test_xcvr_regwr_seq.sv
module test_xcvr_regwr_seq;
    import xcvr_regwr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int T          = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             go_i = 1'b0;
    logic [REG_W-1:0] addr_i = '0;
    logic [REG_W-1:0] data_i = '0;
    logic             ack_i = 1'b0;
    logic [REG_W-1:0] bus_data_o;
    logic [CMD_W-1:0] cmd_o;
    logic             done_o;
    logic             timeout_o;

    xcvr_regwr_seq #(.TIMEOUT_CYC(T)) i_xcvr_regwr_seq (
        .clk        (clk),
        .rst        (rst),
        .go_i       (go_i),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .ack_i      (ack_i),
        .bus_data_o (bus_data_o),
        .cmd_o      (cmd_o),
        .done_o     (done_o),
        .timeout_o  (timeout_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // responder configuration and log
    int               rise_dly = 0, fall_dly = 0, hang_rise = -1, hang_fall = -1;
    int               n_strb = 0, hi_len = 0, lo_len = 0, rcnt = 0, fcnt = 0;
    bit               frozen = 1'b0, setup_bad = 1'b0;
    logic [CMD_W-1:0] log_cmd [8];
    logic [REG_W-1:0] log_bus [8];
    logic [CMD_W-1:0] prev_cmd = '0;
    logic [REG_W-1:0] prev_bus = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural register-port responder
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (cmd_o != '0 && prev_cmd == '0) begin
                    if (n_strb < 8) begin
                        log_cmd[n_strb] = cmd_o;
                        log_bus[n_strb] = bus_data_o;
                    end
                    if (bus_data_o !== prev_bus) setup_bad = 1'b1;
                    n_strb++;
                    rcnt   = 0;
                    hi_len = 0;
                    lo_len = 0;
                    frozen = 1'b0;
                end
                if (timeout_o) frozen = 1'b1;
                if (cmd_o != '0) begin
                    hi_len++;
                    fcnt = 0;
                    if (!ack_i && hang_rise != n_strb - 1) begin
                        if (rcnt >= rise_dly) ack_i = 1'b1;
                        else rcnt++;
                    end
                end else begin
                    if (ack_i && !frozen) lo_len++;
                    if (ack_i && hang_fall != n_strb - 1) begin
                        if (fcnt >= fall_dly) ack_i = 1'b0;
                        else fcnt++;
                    end
                end
            end
            prev_cmd = cmd_o;
            prev_bus = bus_data_o;
        end
    end

    task automatic run_write(input logic [15:0] a, input logic [15:0] d,
                             input int rd, input int fd, input int hr, input int hf,
                             input bit extra_go, input string tag);
        bit got_done, got_to, exp_ok;
        int cyc, strobes_at_end, exp_strb;
        rise_dly  = rd;
        fall_dly  = fd;
        hang_rise = hr;
        hang_fall = hf;
        n_strb    = 0;
        setup_bad = 1'b0;
        got_done  = 1'b0;
        got_to    = 1'b0;
        cyc       = 0;
        @(negedge clk);
        addr_i = a;
        data_i = d;
        go_i   = 1'b1;
        while (!got_done && !got_to && cyc < 200) begin
            @(negedge clk);
            cyc++;
            go_i   = extra_go && (cyc == 4);
            addr_i = ~a ^ 16'(cyc);
            data_i = ~d ^ 16'(cyc * 3);
            if (done_o)    got_done = 1'b1;
            if (timeout_o) got_to   = 1'b1;
        end
        go_i = 1'b0;
        exp_ok = (hr < 0) && (hf < 0) && (rd <= T - 3) && (fd <= T - 3);
        check(got_done == exp_ok, tag, "done seen", int'(got_done), int'(exp_ok));
        check(got_to == !exp_ok, tag, "timeout seen", int'(got_to), int'(!exp_ok));
        @(negedge clk);
        check(!done_o && !timeout_o, "R10", "pulse width",
              int'({done_o, timeout_o}), 0);
        strobes_at_end = n_strb;
        repeat (T + 4) @(negedge clk);
        check(n_strb == strobes_at_end, "R9", "no strobe after end", n_strb, strobes_at_end);
        check(!setup_bad, "R4", "bus set up before strobe", int'(setup_bad), 0);
        if (exp_ok) begin
            check(n_strb == 3, tag, "strobe count", n_strb, 3);
            check(log_cmd[0] == 4'b0001 && log_bus[0] == a, "R3", "address step",
                  int'({log_cmd[0], log_bus[0]}), int'({4'b0001, a}));
            check(log_cmd[1] == 4'b0010 && log_bus[1] == d, "R3", "data step",
                  int'({log_cmd[1], log_bus[1]}), int'({4'b0010, d}));
            check(log_cmd[2] == 4'b1000 && log_bus[2] == d, "R3", "commit step",
                  int'({log_cmd[2], log_bus[2]}), int'({4'b1000, d}));
        end else begin
            exp_strb = (hr >= 0) ? hr + 1 : (hf >= 0) ? hf + 1 : 1;
            check(n_strb == exp_strb, "R7", "steps aborted after timeout", n_strb, exp_strb);
            if (hr >= 0)
                check(hi_len == T, "R7", "strobe high length on hang", hi_len, T);
            if (hf >= 0)
                check(lo_len == T, "R8", "release wait length on hang", lo_len, T);
        end
        hang_rise = -1;
        hang_fall = -1;
        cyc = 0;
        while (ack_i && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cmd_o == '0 && bus_data_o == '0 && !done_o && !timeout_o, "R1",
              "outputs in reset", int'({cmd_o, bus_data_o, done_o, timeout_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_o == '0 && bus_data_o == '0 && !done_o && !timeout_o, "R1",
              "outputs after reset", int'({cmd_o, bus_data_o, done_o, timeout_o}), 0);

        // R2 R3 R5: distinct patterns
        run_write(16'h0015, 16'hA209, 0, 0, -1, -1, 1'b0, "R5");
        run_write(16'h0000, 16'h0000, 1, 2, -1, -1, 1'b0, "R3");
        run_write(16'hFFFF, 16'hFFFF, 2, 1, -1, -1, 1'b0, "R3");
        run_write(16'h1010, 16'h0080, 0, 3, -1, -1, 1'b0, "R2");
        run_write(16'hA5A5, 16'h5A5A, 3, 0, -1, -1, 1'b0, "R5");

        // R6 sweep of acknowledge rise delay around the budget edge
        for (int dl = 0; dl <= T + 1; dl++)
            run_write(16'(16'h0100 + dl), 16'(16'h2000 + dl), dl, 1, -1, -1, 1'b0, "R6");
        // R6 sweep of acknowledge release delay
        for (int dl = 0; dl <= T + 1; dl++)
            run_write(16'(16'h0300 + dl), 16'(16'h4000 + dl), 1, dl, -1, -1, 1'b0, "R6");

        // R8: every wait uses the full budget, counter must reload
        run_write(16'h0012, 16'hA000, T - 3, T - 3, -1, -1, 1'b0, "R8");

        // R7: acknowledge never rises, at each step
        for (int s = 0; s < 3; s++)
            run_write(16'(16'h0700 + s), 16'(16'h7000 + s), 0, 0, s, -1, 1'b0, "R7");
        // R8: acknowledge never falls, at each step
        for (int s = 0; s < 3; s++)
            run_write(16'(16'h0800 + s), 16'(16'h8000 + s), 0, 0, -1, s, 1'b0, "R8");

        // R9: go pulsed mid-write is ignored
        run_write(16'h1234, 16'hBEEF, 1, 1, -1, -1, 1'b1, "R9");
        // recovery after a timeout
        run_write(16'hCAFE, 16'h0F0F, 0, 0, -1, -1, 1'b0, "R10");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule